// File: doc/BRIEF.md
# SPI Master Controller with Register Interface

This block is an SPI master that software drives through a small 32-bit register window. Software queues bytes into a 16-entry transmit FIFO, picks the clock polarity, clock phase and bit order, and selects a slave through an active-low select register. Each byte shifted out produces one received byte in a 16-entry receive FIFO. Software drains that FIFO by reading the receive data register.

A hold bit in the control register stops queued bytes from leaving the transmit FIFO. Software can preload a whole burst while the hold bit is set. When it clears the bit, the burst goes out back to back with no gap between bytes. The slave selects either follow the select register directly, or drop only while bytes are shifting. A loopback setting feeds the serial output back into the receive path, so the block can test itself without a slave. A soft reset takes effect only when one exact key value is written.

Top module: `spim_ctrl`

## Requirements
- R1: After reset, the status register reads 0x5, the control register reads 0x100, the select register reads all ones, every `ss_n` line is high and `sclk` is low.
- R2: The register offsets are 0x40 soft reset, 0x60 control, 0x64 status, 0x68 transmit data, 0x6C receive data and 0x70 slave select. Offsets that are not mapped read as 0. The control register holds bit 0 loopback, bit 1 system enable, bit 2 master enable, bit 3 CPOL, bit 4 CPHA, bit 7 manual select and bit 8 hold, and bit 9 LSB-first. These bits read back as written.
- R3: Writing exactly 0x0000000A to offset 0x40 returns control, select and both FIFOs to their reset state. Any other value written there changes nothing.
- R4: The transmit FIFO holds 16 bytes. Each write to offset 0x68 queues bits 7:0. A write while the FIFO is full is dropped. Status bit 3 means transmit full and status bit 2 means transmit empty.
- R5: Each read of offset 0x6C returns the oldest received byte and removes it. A read while the receive FIFO is empty returns 0. Status bit 0 means receive empty and status bit 1 means receive full.
- R6: While control bit 8 is set, no byte leaves the transmit FIFO. Once the bit is clear, queued bytes shift out back to back until the FIFO is empty. Each byte then takes exactly 16*CLK_DIV clock cycles.
- R7: `sclk` idles at the CPOL level, and each half period lasts CLK_DIV clock cycles. With CPHA=0, data is sampled on the leading edge and changed on the trailing edge. With CPHA=1, these edges are swapped.
- R8: With control bit 9 clear, bytes go out and come in MSB first. With bit 9 set, they go LSB first.
- R9: With control bit 0 set, the receive path takes `mosi` and ignores `miso`.
- R10: With control bit 7 set, `ss_n` follows the select register at all times. A clear bit n selects slave n.
- R11: With control bit 7 clear, `ss_n` equals the select register only while bytes are shifting. At all other times it is all ones.
- R12: Control bits 5 and 6 always read 0. Writing 1 to bit 5 empties only the transmit FIFO, and writing 1 to bit 6 empties only the receive FIFO.
- R13: A byte leaves the transmit FIFO only when control bits 1 and 2 are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; pops the receive FIFO at offset 0x6C |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | NUM_SS | Active-low slave selects |

## Verification
The shift engine and the register port can act on the same FIFO in one cycle. The engine can pop the transmit FIFO while software pushes into it, and it can push a received byte while software pops the receive FIFO. The bench provokes this by queuing a 17-byte burst under hold and then releasing it in loopback. It checks that exactly the first 16 bytes come back in order, and that the select line stays low for exactly 16 byte times with a single rising edge. Mode and bit-order behaviour are checked by a bench-side slave model that samples `mosi` and drives `miso` on edges it works out from CPOL and CPHA by itself.

// File: rtl/spim_pkg.sv
package spim_pkg;
  // register byte offsets
  localparam logic [7:0] OFF_SRST = 8'h40;
  localparam logic [7:0] OFF_CTRL = 8'h60;
  localparam logic [7:0] OFF_STAT = 8'h64;
  localparam logic [7:0] OFF_TXD  = 8'h68;
  localparam logic [7:0] OFF_RXD  = 8'h6C;
  localparam logic [7:0] OFF_SSEL = 8'h70;

  // control bit positions
  localparam int CB_LOOP  = 0;
  localparam int CB_SYSEN = 1;
  localparam int CB_MSTEN = 2;
  localparam int CB_CPOL  = 3;
  localparam int CB_CPHA  = 4;
  localparam int CB_TXCLR = 5;
  localparam int CB_RXCLR = 6;
  localparam int CB_MANSS = 7;
  localparam int CB_HOLD  = 8;
  localparam int CB_LSB   = 9;
  localparam int CTRL_W   = 10;

  localparam logic [CTRL_W-1:0] CTRL_RST = 10'h100;
  localparam logic [CTRL_W-1:0] CTRL_KEEP_MASK = 10'h39F;
  localparam logic [31:0] SRST_KEY = 32'h0000_000A;
endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  output logic         full,
  output logic         empty
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = PTR_W + 1;

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] cnt;
  logic             wr_ok, rd_ok;

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full  = (cnt == CNT_W'(DEPTH));
  assign empty = (cnt == '0);
  assign wr_ok = push && !full;
  assign rd_ok = pop && !empty;
  assign rdata = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (wr_ok) wr_ptr <= ptr_next(wr_ptr);
      if (rd_ok) rd_ptr <= ptr_next(rd_ptr);
      case ({wr_ok, rd_ok})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/spim_engine.sv
module spim_engine #(
  parameter int DATA_W  = 8,
  parameter int CLK_DIV = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              go,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              lsb_first,
  input  logic              loopback,
  input  logic              tx_empty,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              miso,
  output logic              tx_pop,
  output logic              rx_push,
  output logic [DATA_W-1:0] rx_data,
  output logic              busy,
  output logic              sclk,
  output logic              mosi,
  output logic              done_byte
);
  localparam int EDGES  = 2 * DATA_W;
  localparam int EDGE_W = $clog2(EDGES);
  localparam int DIV_W  = $clog2(CLK_DIV + 1);
  localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(EDGES - 1);
  localparam logic [DIV_W-1:0]  DIV_LAST  = DIV_W'(CLK_DIV - 1);

  function automatic logic [DATA_W-1:0] shift_in(input logic [DATA_W-1:0] cur,
                                                 input logic b, input logic lsb);
    return lsb ? {b, cur[DATA_W-1:1]} : {cur[DATA_W-2:0], b};
  endfunction

  function automatic logic [DATA_W-1:0] shift_out(input logic [DATA_W-1:0] cur,
                                                  input logic lsb);
    return lsb ? {1'b0, cur[DATA_W-1:1]} : {cur[DATA_W-2:0], 1'b0};
  endfunction

  function automatic logic out_bit(input logic [DATA_W-1:0] cur, input logic lsb);
    return lsb ? cur[0] : cur[DATA_W-1];
  endfunction

  logic              busy_q, sclk_q;
  logic [DIV_W-1:0]  div_q;
  logic [EDGE_W-1:0] edge_q;
  logic [DATA_W-1:0] tx_sh, rx_sh, rx_nx;
  logic              tick, last_tick, sample_edge, shift_edge, start, rx_in;

  assign tick        = busy_q && (div_q == DIV_LAST);
  assign last_tick   = tick && (edge_q == LAST_EDGE);
  assign sample_edge = tick && (edge_q[0] == cpha);
  assign shift_edge  = tick && (edge_q[0] != cpha) && (edge_q != '0);
  assign start       = go && !tx_empty && (!busy_q || last_tick);

  assign mosi      = out_bit(tx_sh, lsb_first);
  assign rx_in     = loopback ? mosi : miso;
  assign rx_nx     = shift_in(rx_sh, rx_in, lsb_first);
  assign rx_data   = sample_edge ? rx_nx : rx_sh;
  assign rx_push   = last_tick;
  assign done_byte = last_tick;
  assign tx_pop    = start;
  assign busy      = busy_q;
  assign sclk      = busy_q ? sclk_q : cpol;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sclk_q <= 1'b0;
      div_q  <= '0;
      edge_q <= '0;
      tx_sh  <= '0;
      rx_sh  <= '0;
    end else if (clr) begin
      busy_q <= 1'b0;
      sclk_q <= 1'b0;
      div_q  <= '0;
      edge_q <= '0;
      tx_sh  <= '0;
      rx_sh  <= '0;
    end else begin
      if (tick) begin
        div_q  <= '0;
        sclk_q <= ~sclk_q;
        edge_q <= edge_q + 1'b1;
        if (sample_edge) rx_sh <= rx_nx;
        if (shift_edge)  tx_sh <= shift_out(tx_sh, lsb_first);
      end else if (busy_q) begin
        div_q <= div_q + 1'b1;
      end
      if (last_tick) busy_q <= 1'b0;
      if (start) begin
        busy_q <= 1'b1;
        tx_sh  <= tx_data;
        sclk_q <= cpol;
        div_q  <= '0;
        edge_q <= '0;
      end
    end
  end
endmodule

// File: rtl/spim_ctrl.sv
module spim_ctrl
  import spim_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int FIFO_DEPTH = 16,
  parameter int NUM_SS     = 4,
  parameter int CLK_DIV    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [7:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic [NUM_SS-1:0] ss_n
);
  logic [CTRL_W-1:0] ctrl_q;
  logic [NUM_SS-1:0] ss_q;

  // named internal events
  logic soft_rst, ctrl_we, ss_we, tx_push, rx_pop, rx_rd;
  logic tx_flush, rx_flush, tx_pop, rx_push, busy, done_byte, go;
  logic tx_full, tx_empty, rx_full, rx_empty;
  logic manual_mode, cpol_w, hold_w;
  logic [DATA_W-1:0] tx_head, rx_head, rx_byte;

  assign soft_rst = reg_wr && (reg_addr == OFF_SRST) && (reg_wdata == SRST_KEY);
  assign ctrl_we  = reg_wr && (reg_addr == OFF_CTRL);
  assign ss_we    = reg_wr && (reg_addr == OFF_SSEL);
  assign tx_push  = reg_wr && (reg_addr == OFF_TXD);
  assign rx_rd    = reg_rd && (reg_addr == OFF_RXD);
  assign rx_pop   = rx_rd && !rx_empty;
  assign tx_flush = soft_rst || (ctrl_we && reg_wdata[CB_TXCLR]);
  assign rx_flush = soft_rst || (ctrl_we && reg_wdata[CB_RXCLR]);

  assign manual_mode = ctrl_q[CB_MANSS];
  assign cpol_w      = ctrl_q[CB_CPOL];
  assign hold_w      = ctrl_q[CB_HOLD];
  assign go          = ctrl_q[CB_SYSEN] && ctrl_q[CB_MSTEN] && !hold_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RST;
      ss_q   <= '1;
    end else if (soft_rst) begin
      ctrl_q <= CTRL_RST;
      ss_q   <= '1;
    end else begin
      if (ctrl_we) ctrl_q <= reg_wdata[CTRL_W-1:0] & CTRL_KEEP_MASK;
      if (ss_we)   ss_q   <= reg_wdata[NUM_SS-1:0];
    end
  end

  spim_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .flush(tx_flush), .push(tx_push), .pop(tx_pop),
    .wdata(reg_wdata[DATA_W-1:0]), .rdata(tx_head), .full(tx_full), .empty(tx_empty)
  );

  spim_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .flush(rx_flush), .push(rx_push), .pop(rx_pop),
    .wdata(rx_byte), .rdata(rx_head), .full(rx_full), .empty(rx_empty)
  );

  spim_engine #(.DATA_W(DATA_W), .CLK_DIV(CLK_DIV)) u_eng (
    .clk(clk), .rst_n(rst_n), .clr(soft_rst), .go(go),
    .cpol(cpol_w), .cpha(ctrl_q[CB_CPHA]), .lsb_first(ctrl_q[CB_LSB]),
    .loopback(ctrl_q[CB_LOOP]), .tx_empty(tx_empty), .tx_data(tx_head),
    .miso(miso), .tx_pop(tx_pop), .rx_push(rx_push), .rx_data(rx_byte),
    .busy(busy), .sclk(sclk), .mosi(mosi), .done_byte(done_byte)
  );

  assign ss_n = (manual_mode || busy) ? ss_q : '1;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      OFF_CTRL: reg_rdata = {{(32-CTRL_W){1'b0}}, ctrl_q};
      OFF_STAT: reg_rdata = {26'd0, 2'b00, tx_full, tx_empty, rx_full, rx_empty};
      OFF_RXD:  reg_rdata = rx_empty ? '0 : {{(32-DATA_W){1'b0}}, rx_head};
      OFF_SSEL: reg_rdata = {{(32-NUM_SS){1'b0}}, ss_q};
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/spim_ctrl_chk.sv
module spim_ctrl_chk #(
  parameter int NUM_SS = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sclk,
  input logic [NUM_SS-1:0] ss_n,
  input logic [NUM_SS-1:0] ss_q,
  input logic              manual_mode,
  input logic              cpol_w,
  input logic              hold_w,
  input logic              busy,
  input logic              soft_rst,
  input logic              ctrl_we,
  input logic              tx_flush,
  input logic              rx_flush,
  input logic              tx_full,
  input logic              tx_empty,
  input logic              rx_empty,
  input logic              tx_push,
  input logic              tx_pop,
  input logic              rx_rd,
  input logic [31:0]       reg_rdata,
  input logic              done_byte
);
  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_full && tx_push && !tx_pop) |=> tx_full);

  // R6
  hold_keeps_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_w && !busy) |=> !busy);

  // R3
  soft_rst_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (tx_empty && rx_empty && (&ss_n) && !sclk));

  // R12
  tx_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_flush |=> tx_empty);

  // R12
  rx_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_flush |=> rx_empty);

  // R5
  empty_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_rd && rx_empty) |-> (reg_rdata == 32'd0));

  // R7
  idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_byte && !ctrl_we) |=> (sclk == cpol_w));

  // R11
  auto_ss_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!manual_mode && $stable(manual_mode) && (sclk != $past(sclk)) &&
     $stable(cpol_w) && $stable(ss_q) && !(&ss_q)) |-> !(&$past(ss_n)));
endmodule

bind spim_ctrl spim_ctrl_chk #(.NUM_SS(NUM_SS)) u_chk (
  .clk(clk), .rst_n(rst_n), .sclk(sclk), .ss_n(ss_n), .ss_q(ss_q),
  .manual_mode(manual_mode), .cpol_w(cpol_w), .hold_w(hold_w), .busy(busy),
  .soft_rst(soft_rst), .ctrl_we(ctrl_we), .tx_flush(tx_flush), .rx_flush(rx_flush),
  .tx_full(tx_full), .tx_empty(tx_empty), .rx_empty(rx_empty), .tx_push(tx_push),
  .tx_pop(tx_pop), .rx_rd(rx_rd), .reg_rdata(reg_rdata), .done_byte(done_byte)
);

// File: tb/spim_ctrl_test.sv
module spim_ctrl_test;
  localparam int HALF = 2;       // CLK_DIV default of the design
  localparam int BYTE_CYC = 16 * HALF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0]  reg_addr = 8'h00;
  logic [31:0] reg_wdata = 32'h0;
  logic [31:0] reg_rdata;
  logic        sclk, mosi, miso;
  logic [3:0]  ss_n;

  spim_ctrl uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sclk(sclk), .mosi(mosi),
    .miso(miso), .ss_n(ss_n)
  );

  always #5 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  // bench mirror of the programmed mode
  logic b_cpol = 0, b_cpha = 0, b_lsb = 0;
  logic [7:0] slave_byte = 8'h00;

  // negedge monitor / slave model state
  int   cyc = 0;
  logic prev_sclk = 0;
  logic [3:0] prev_ssn = 4'hF;
  int   k = 0;
  logic [7:0] mon_sh = 0, mon_last = 0;
  int   mon_cnt = 0;
  int   lead_prev = -1, lead_period = 0;
  int   ss_low_cnt = 0, ss_rise_cnt = 0;

  assign miso = slave_byte[b_lsb ? k : 7 - k];

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (ss_n != 4'hF) ss_low_cnt <= ss_low_cnt + 1;
    if (prev_ssn != 4'hF && ss_n == 4'hF) begin
      ss_rise_cnt <= ss_rise_cnt + 1;
      lead_prev <= -1;
    end
    if (sclk != prev_sclk && prev_ssn != 4'hF) begin
      if (sclk != b_cpol) begin
        if (lead_prev >= 0) lead_period <= cyc - lead_prev;
        lead_prev <= cyc;
      end
      if ((sclk != b_cpol) != b_cpha) begin
        if (k == 7) begin
          mon_last <= b_lsb ? {mosi, mon_sh[7:1]} : {mon_sh[6:0], mosi};
          mon_cnt  <= mon_cnt + 1;
          k <= 0;
        end else begin
          k <= k + 1;
        end
        mon_sh <= b_lsb ? {mosi, mon_sh[7:1]} : {mon_sh[6:0], mosi};
      end
    end
    prev_sclk <= sclk;
    prev_ssn  <= ss_n;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic clear_mon();
    @(negedge clk);
    #1;
    k = 0; mon_cnt = 0; ss_low_cnt = 0; ss_rise_cnt = 0; lead_period = 0; lead_prev = -1;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(8'h64, d); check("R1 status", d, 32'h5);
    rd(8'h60, d); check("R1 ctrl", d, 32'h100);
    rd(8'h70, d); check("R1 sel reg", d, 32'hF);
    check("R1 ss_n", {28'd0, ss_n}, 32'hF);
    check("R1 sclk", {31'd0, sclk}, 32'h0);
    rd(8'h6C, d); check("R5 empty read", d, 32'h0);
    rd(8'h44, d); check("R2 unmapped", d, 32'h0);
  endtask

  task automatic t_ctrl_rw();
    logic [31:0] d;
    wr(8'h60, 32'h3FF);
    rd(8'h60, d); check("R2/R12 ctrl readback", d, 32'h39F);
    wr(8'h60, 32'h100);
    rd(8'h60, d); check("R2 ctrl restore", d, 32'h100);
  endtask

  task automatic t_select();
    wr(8'h60, 32'h180);
    wr(8'h70, 32'h6);
    @(negedge clk); check("R10 manual follows", {28'd0, ss_n}, 32'h6);
    wr(8'h70, 32'h9);
    @(negedge clk); check("R10 manual follows 2", {28'd0, ss_n}, 32'h9);
    wr(8'h60, 32'h100);
    @(negedge clk); check("R11 auto idle high", {28'd0, ss_n}, 32'hF);
  endtask

  task automatic t_burst();
    logic [31:0] d;
    b_cpol = 0; b_cpha = 0; b_lsb = 0; slave_byte = 8'h00;
    wr(8'h70, 32'hE);
    wr(8'h60, 32'h107);
    for (int i = 0; i < 17; i++) wr(8'h68, 32'h30 + i);
    rd(8'h64, d); check("R4 tx full", d, 32'h9);
    repeat (100) @(negedge clk);
    check("R6 hold keeps ss", {28'd0, ss_n}, 32'hF);
    rd(8'h64, d); check("R6 hold keeps fifo", d, 32'h9);
    clear_mon();
    wr(8'h60, 32'h007);
    repeat (16 * BYTE_CYC + 20) @(negedge clk);
    rd(8'h64, d); check("R6 drained / R5 rx full", d, 32'h6);
    check("R6 back to back low time", ss_low_cnt, 16 * BYTE_CYC);
    check("R11 single select window", ss_rise_cnt, 1);
    check("R8 bytes seen on mosi", mon_cnt, 16);
    for (int i = 0; i < 16; i++) begin
      rd(8'h6C, d); check("R9 loopback byte / R4 order", d, 32'h30 + i);
    end
    rd(8'h6C, d); check("R4 17th dropped / R5 empty", d, 32'h0);
    wr(8'h60, 32'h100);
  endtask

  task automatic t_mode(input logic cp, input logic ph, input logic lsb,
                        input logic [7:0] txb, input logic [7:0] slv);
    logic [31:0] d, c;
    c = 32'h106 | ({31'd0, cp} << 3) | ({31'd0, ph} << 4) | ({31'd0, lsb} << 9);
    b_cpol = cp; b_cpha = ph; b_lsb = lsb; slave_byte = slv;
    wr(8'h60, c);
    wr(8'h68, {24'd0, txb});
    clear_mon();
    wr(8'h60, c & ~32'h100);
    repeat (BYTE_CYC + 10) @(negedge clk);
    check("R7/R8 mosi byte", {24'd0, mon_last}, {24'd0, txb});
    check("R7 leading edge period", lead_period, 2 * HALF);
    check("R7 idle level", {31'd0, sclk}, {31'd0, cp});
    rd(8'h6C, d); check("R7/R8 miso byte", d, {24'd0, slv});
    wr(8'h60, 32'h100);
  endtask

  task automatic t_enables();
    logic [31:0] d;
    wr(8'h60, 32'h004);
    wr(8'h68, 32'h55);
    repeat (60) @(negedge clk);
    rd(8'h64, d); check("R13 master only", d, 32'h1);
    wr(8'h60, 32'h002);
    repeat (60) @(negedge clk);
    rd(8'h64, d); check("R13 system only", d, 32'h1);
    check("R13 no select", {28'd0, ss_n}, 32'hF);
    wr(8'h60, 32'h120);
    rd(8'h64, d); check("R12 tx clear", d, 32'h5);
  endtask

  task automatic t_fifo_clr();
    logic [31:0] d;
    b_cpol = 0; b_cpha = 0; b_lsb = 0;
    wr(8'h60, 32'h107);
    wr(8'h68, 32'hA1); wr(8'h68, 32'hA2);
    wr(8'h60, 32'h007);
    repeat (2 * BYTE_CYC + 10) @(negedge clk);
    wr(8'h60, 32'h107);
    for (int i = 0; i < 3; i++) wr(8'h68, 32'h10 + i);
    rd(8'h64, d); check("R12 both hold data", d, 32'h0);
    wr(8'h60, 32'h127);
    rd(8'h64, d); check("R12 tx only cleared", d, 32'h4);
    rd(8'h60, d); check("R12 self clear", d, 32'h107);
    wr(8'h60, 32'h147);
    rd(8'h64, d); check("R12 rx cleared", d, 32'h5);
  endtask

  task automatic t_soft_reset();
    logic [31:0] d;
    wr(8'h60, 32'h18F);
    wr(8'h70, 32'h5);
    wr(8'h68, 32'h11);
    wr(8'h40, 32'h5);
    rd(8'h60, d); check("R3 wrong key ctrl", d, 32'h18F);
    rd(8'h64, d); check("R3 wrong key fifo", d, 32'h1);
    check("R3 wrong key ss / R10", {28'd0, ss_n}, 32'h5);
    wr(8'h40, 32'hA);
    rd(8'h60, d); check("R3 key ctrl", d, 32'h100);
    rd(8'h64, d); check("R3 key status", d, 32'h5);
    rd(8'h70, d); check("R3 key sel", d, 32'hF);
    check("R3 key ss_n", {28'd0, ss_n}, 32'hF);
    check("R3 key sclk", {31'd0, sclk}, 32'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_ctrl_rw();
    t_select();
    t_burst();
    t_mode(0, 0, 0, 8'hA5, 8'h3C);
    t_mode(0, 1, 0, 8'h96, 8'hC1);
    t_mode(1, 0, 0, 8'h0F, 8'h81);
    t_mode(1, 1, 0, 8'hE2, 8'h5A);
    t_mode(0, 0, 1, 8'h01, 8'h80);
    t_mode(0, 1, 1, 8'hC4, 8'h17);
    t_mode(1, 0, 1, 8'h6B, 8'hD2);
    t_mode(1, 1, 1, 8'h3A, 8'h4E);
    t_enables();
    t_fifo_clr();
    t_soft_reset();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule